// File: doc/BRIEF.md
# Edge-Counting Timer Interrupt Unit

This block is a countdown interrupt timer on a CPU write bus. It counts falling transitions of one of two asynchronous event inputs: a video address line (A12), which toggles as the video fetch moves between pattern areas, or horizontal sync. Software writes an 8-bit preload value and then writes the load strobe, which copies the preload into the counter and starts it. Each counted falling transition moves the counter down by one. When a transition arrives while the counter is already at zero, the timer expires and the counter reloads from the preload, so the timer repeats with a fixed period.

Expiry drives a level interrupt request, but only while the interrupt is enabled. The request stays high until software writes the disable strobe, which acts as the acknowledge. The enable and disable strobes, like the load strobe, ignore the data written with them. A one-bit source select register chooses which input is counted. Both inputs pass through a two-flop synchronizer. The asynchronous reset is released in step with the clock.

Top module: `edge_irq_timer`

## Requirements
- R1: After reset, irq is low, the interrupt is disabled, the counter is stopped, the preload is 0 and the source select is 0 (A12).
- R2: A write to address 0 stores wr_data[7:0] as the preload. A write of any data to address 1 (load strobe) copies the preload into the counter and starts counting.
- R3: While running, each falling transition of the selected input counts, and rising transitions do not. A fall that finds the counter above zero decrements it. A fall that finds it at zero is an expiry and reloads the preload. With preload N, expiries occur on fall N+1, then on every N+1 falls after that.
- R4: With preload 0, the first counted fall after a load is an expiry.
- R5: Bit 0 of a write to address 4 selects the source: 0 counts a12_in and 1 counts hsync_in. Transitions on the unselected input have no effect.
- R6: A write of any data to address 3 enables the interrupt. An expiry while enabled sets irq, and irq stays high until a disable write.
- R7: A write of any data to address 2 disables the interrupt and clears irq. An expiry while disabled leaves irq low, and the counter still reloads and keeps running.
- R8: Before the first load, transitions on either input never raise irq, even with the interrupt enabled and preload 0.
- R9: irq rises on the third rising clock edge after the selected input falls (two synchronizer flops and one counter register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Register address: 0 preload, 1 load, 2 disable, 3 enable, 4 source select |
| wr_data | input | 8 | Write data |
| a12_in | input | 1 | Asynchronous video address line event input |
| hsync_in | input | 1 | Asynchronous horizontal sync event input |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong count or reload value shows up at irq as an expiry one or more falls too early or too late. A directed test can pin this down only by checking irq after every individual fall, which is what the bench does. A wrong enable or pending state shows up as irq rising while disabled, dropping without a disable write, or staying high after one. These faults are visible within the three-cycle latency of the fall that should or should not have fired. A wrong source mux shows up as a fire on the unselected input. The exact-latency check catches an extra or missing synchronizer stage on the first expiry.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_PRELOAD = 3'd0,
    ADDR_LOAD    = 3'd1,
    ADDR_DISABLE = 3'd2,
    ADDR_ENABLE  = 3'd3,
    ADDR_SRCSEL  = 3'd4
  } tmr_addr_e;

  localparam int NUM_SRC = 2;
  localparam int SRC_A12 = 0;
  localparam int SRC_HS  = 1;
endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  // sh[STAGES-1:0] synchronize, sh[STAGES] holds the previous synced value
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign fall = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  preload_q,
  output logic              src_sel_q,
  output logic              ld_stb,
  output logic              dis_stb,
  output logic              en_stb
);
  logic pre_we;
  logic sel_we;

  always_comb begin
    pre_we  = wr_en && (wr_addr == ADDR_PRELOAD);
    sel_we  = wr_en && (wr_addr == ADDR_SRCSEL);
    ld_stb  = wr_en && (wr_addr == ADDR_LOAD);
    dis_stb = wr_en && (wr_addr == ADDR_DISABLE);
    en_stb  = wr_en && (wr_addr == ADDR_ENABLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      preload_q <= '0;
    else if (pre_we) preload_q <= wr_data[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      src_sel_q <= 1'b0;
    else if (sel_we) src_sel_q <= wr_data[0];
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_stb,
  input  logic             dis_stb,
  input  logic             en_stb,
  input  logic             tick,
  input  logic [CNT_W-1:0] preload,
  output logic [CNT_W-1:0] cnt_q,
  output logic             run_q,
  output logic             en_q,
  output logic             irq_q
);
  logic [CNT_W-1:0] cnt_d;
  logic             run_d;
  logic             en_d;
  logic             irq_d;
  logic             expire;

  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    en_d   = en_q;
    irq_d  = irq_q;
    expire = run_q && tick && (cnt_q == '0) && !ld_stb;

    if (ld_stb) begin
      cnt_d = preload;
      run_d = 1'b1;
    end else if (run_q && tick) begin
      cnt_d = (cnt_q == '0) ? preload : cnt_q - 1'b1;
    end

    if (en_stb)  en_d = 1'b1;
    if (dis_stb) en_d = 1'b0;

    if (expire && en_q) irq_d = 1'b1;
    if (dis_stb)        irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      en_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      en_q  <= en_d;
      irq_q <= irq_d;
    end
  end
endmodule

// File: rtl/edge_irq_timer.sv
module edge_irq_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              a12_in,
  input  logic              hsync_in,
  output logic              irq
);
  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_n_s = rst_pipe[RST_STAGES-1];

  logic [NUM_SRC-1:0] src_raw;
  logic [NUM_SRC-1:0] src_fall;
  assign src_raw[SRC_A12] = a12_in;
  assign src_raw[SRC_HS]  = hsync_in;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n_s),
      .din  (src_raw[g]),
      .fall (src_fall[g])
    );
  end

  logic [CNT_W-1:0] preload;
  logic             src_sel;
  logic             ld_stb;
  logic             dis_stb;
  logic             en_stb;
  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic             running;
  logic             irq_en;

  tmr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .preload_q(preload),
    .src_sel_q(src_sel),
    .ld_stb   (ld_stb),
    .dis_stb  (dis_stb),
    .en_stb   (en_stb)
  );

  assign tick = src_sel ? src_fall[SRC_HS] : src_fall[SRC_A12];

  tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .ld_stb (ld_stb),
    .dis_stb(dis_stb),
    .en_stb (en_stb),
    .tick   (tick),
    .preload(preload),
    .cnt_q  (cnt),
    .run_q  (running),
    .en_q   (irq_en),
    .irq_q  (irq)
  );
endmodule

// File: rtl/edge_irq_timer_chk.sv
module edge_irq_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n_s,
  input logic             ld_stb,
  input logic             dis_stb,
  input logic             en_stb,
  input logic             tick,
  input logic [CNT_W-1:0] preload,
  input logic [CNT_W-1:0] cnt,
  input logic             running,
  input logic             irq_en,
  input logic             irq
);
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    ld_stb |=> (running && cnt == $past(preload)));

  p_hold_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (running && !ld_stb && !tick) |=> $stable(cnt));

  p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (irq && !dis_stb) |=> irq);

  p_irq_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(irq) |-> $past(irq_en));

  p_en_set_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (en_stb && !dis_stb) |=> irq_en);

  p_dis_clr_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    dis_stb |=> (!irq && !irq_en));

  p_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!running && !ld_stb) |=> (!running && $stable(cnt) && !$rose(irq)));
endmodule

bind edge_irq_timer edge_irq_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n_s(rst_n_s),
  .ld_stb (ld_stb),
  .dis_stb(dis_stb),
  .en_stb (en_stb),
  .tick   (tick),
  .preload(preload),
  .cnt    (cnt),
  .running(running),
  .irq_en (irq_en),
  .irq    (irq)
);

// File: tb/edge_irq_timer_tb_top.sv
module edge_irq_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic       a12_in;
  logic       hsync_in;
  logic       irq;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_irq_timer dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .a12_in  (a12_in),
    .hsync_in(hsync_in),
    .irq     (irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // one low-then-high pulse on a source, irq checked after the fall settles
  task automatic pulse(input bit hs, input bit exp, input string req);
    @(negedge clk);
    if (hs) hsync_in = 1'b0; else a12_in = 1'b0;
    repeat (4) @(negedge clk);
    chk(irq == exp, req, irq, exp);
    if (hs) hsync_in = 1'b1; else a12_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(irq == 1'b0, "R1 irq low after reset", irq, 0);
  endtask

  task automatic t_stopped;
    reg_wr(3'd3, 8'h00);
    pulse(1'b0, 1'b0, "R8 no count before load (a12)");
    pulse(1'b1, 1'b0, "R8 no count before load (hsync)");
    pulse(1'b0, 1'b0, "R8 no count before load, second a12");
    reg_wr(3'd2, 8'h00);
  endtask

  task automatic t_basic;
    reg_wr(3'd0, 8'd3);
    reg_wr(3'd3, 8'h5A);
    reg_wr(3'd1, 8'hA5);          // load data value is ignored (R2)
    pulse(1'b0, 1'b0, "R3 fall 1 of 4");
    pulse(1'b0, 1'b0, "R3 fall 2 of 4");
    pulse(1'b0, 1'b0, "R2 R3 fall 3 of 4, default source a12 (R1)");
    @(negedge clk);
    a12_in = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk(irq == 1'b0, "R9 irq low after two edges", irq, 0);
    @(posedge clk); #1;
    chk(irq == 1'b1, "R9 irq high on third edge", irq, 1);
    repeat (3) @(negedge clk);
    a12_in = 1'b1;
    repeat (10) @(negedge clk);
    chk(irq == 1'b1, "R6 irq held", irq, 1);
    reg_wr(3'd3, 8'hFF);
    chk(irq == 1'b1, "R6 enable write keeps irq", irq, 1);
    reg_wr(3'd2, 8'h33);
    chk(irq == 1'b0, "R7 disable clears irq", irq, 0);
  endtask

  task automatic t_zero;
    reg_wr(3'd0, 8'd0);
    reg_wr(3'd3, 8'h00);
    reg_wr(3'd1, 8'h00);
    pulse(1'b0, 1'b1, "R4 preload zero fires on first fall");
    reg_wr(3'd2, 8'h00);
    chk(irq == 1'b0, "R7 disable clears irq after zero preload", irq, 0);
  endtask

  task automatic t_reload;
    reg_wr(3'd0, 8'd1);
    reg_wr(3'd1, 8'h00);
    pulse(1'b0, 1'b0, "R7 disabled, fall 1");
    pulse(1'b0, 1'b0, "R7 disabled expiry leaves irq low");
    reg_wr(3'd3, 8'h00);
    pulse(1'b0, 1'b0, "R3 after reload, fall 1 of 2");
    pulse(1'b0, 1'b1, "R3 R7 periodic expiry after silent reload");
    reg_wr(3'd2, 8'h00);
  endtask

  task automatic t_select;
    reg_wr(3'd4, 8'h01);
    reg_wr(3'd0, 8'd0);
    reg_wr(3'd3, 8'h00);
    reg_wr(3'd1, 8'h00);
    pulse(1'b0, 1'b0, "R5 a12 ignored when hsync selected");
    pulse(1'b1, 1'b1, "R5 hsync counted when selected");
    reg_wr(3'd2, 8'h00);
    reg_wr(3'd4, 8'hFE);          // bit 0 = 0 selects a12
    reg_wr(3'd3, 8'h00);
    reg_wr(3'd1, 8'h00);
    pulse(1'b1, 1'b0, "R5 hsync ignored when a12 selected");
    pulse(1'b0, 1'b1, "R5 a12 counted when selected");
    reg_wr(3'd2, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    a12_in = 1'b1; hsync_in = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_stopped();
    t_basic();
    t_zero();
    t_reload();
    t_select();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule